// File: doc/BRIEF.md
# Parallel Port Expander Register Set

This block holds the configuration and status registers of an eight-bit parallel port expander that sits behind a serial bus slave. The bus engine decodes a transfer into a command byte, plus an optional data byte. It presents them on two strobes. A data strobe stores the data byte into the register named by the command code. A command-only strobe triggers the two action codes: resample the address-select pins, and restore every register to its power-on value.

Two banks of three registers exist. Each bank has a drive-level register for the port pins, a mask for low-to-high interrupts and a mask for high-to-low interrupts. A `suspend` input chooses which bank feeds the pin and mask outputs. The switch is combinational and needs no bus traffic. A read multiplexer serves the bus engine. It returns the stored registers, the live pin levels, a fixed identification byte, or zero for codes that are not assigned. Stored values change at the clock edge that samples the strobe, so they are in place before the bus transfer closes.

Top module: `ioexp_regfile`

## Requirements
- R1: After hardware reset the normal drive register holds 00h, the suspend drive register and all four masks hold FFh, and the latched address is 0.
- R2: A data write with code 00h, 01h or 02h loads the normal drive level, normal rising mask or normal falling mask. Reading the same code returns the stored value.
- R3: A data write with code 03h, 04h or 05h loads the suspend drive level, suspend rising mask or suspend falling mask. Reading the same code returns the stored value.
- R4: With `suspend` low, `io_out`, `rise_mask` and `fall_mask` show the normal bank. With it high, they show the suspend bank. They follow `suspend` in the same cycle.
- R5: Reading code 06h returns the present value of `io_in`. A data write with code 06h changes no register.
- R6: A command strobe with code 07h copies `addr_pins` into `addr_sel` at that clock edge.
- R7: A command strobe with code 08h returns all six registers to their R1 values and copies `addr_pins` into `addr_sel`, both at that clock edge.
- R8: Reading code FEh returns 4Dh. A data write with code FEh changes no register.
- R9: Reading any code not listed in R2, R3, R5 or R8 returns 00h. A data write with such a code changes no register.
- R10: A data write takes effect at the rising clock edge that samples `dat_stb`. The outputs keep their old value until that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_code | input | 8 | Command code shared by both strobes |
| dat_stb | input | 1 | Store `dat_byte` into the register selected by `cmd_code` |
| dat_byte | input | W | Data byte to store |
| cmd_stb | input | 1 | Execute an action code (07h, 08h) |
| rd_code | input | 8 | Code to read |
| rd_data | output | W | Read result for `rd_code`, combinational |
| suspend | input | 1 | Selects the suspend bank for the outputs |
| io_in | input | W | Live port pin levels |
| io_out | output | W | Drive level from the selected bank |
| rise_mask | output | W | Low-to-high interrupt mask from the selected bank |
| fall_mask | output | W | High-to-low interrupt mask from the selected bank |
| addr_pins | input | ADDR_W | Address-select pin levels |
| addr_sel | output | ADDR_W | Last sampled address-select value |

## Verification
Stored registers and the latched address pass through one register. The result of a strobe is therefore due from the rising edge that samples it. The bench drives strobes on the falling edge and samples 1 ns after the next rising edge. For R10, it also checks `io_out` while the strobe is still pending, before that edge. The read path, the pin status and the `suspend` switch are combinational, so they are due in the same cycle. The bench checks them 1 ns after changing the input, with no clock edge in between.

// File: rtl/ioexp_pkg.sv
package ioexp_pkg;
  localparam logic [7:0] CMD_NPIN  = 8'h00;
  localparam logic [7:0] CMD_NRISE = 8'h01;
  localparam logic [7:0] CMD_NFALL = 8'h02;
  localparam logic [7:0] CMD_SPIN  = 8'h03;
  localparam logic [7:0] CMD_SRISE = 8'h04;
  localparam logic [7:0] CMD_SFALL = 8'h05;
  localparam logic [7:0] CMD_STAT  = 8'h06;
  localparam logic [7:0] CMD_ASMP  = 8'h07;
  localparam logic [7:0] CMD_SRST  = 8'h08;
  localparam logic [7:0] CMD_ID    = 8'hFE;
  localparam logic [7:0] ID_BYTE   = 8'h4D;

  // slot inside a bank: 0 drive level, 1 rising mask, 2 falling mask
  function automatic logic [1:0] bank_slot(input logic [7:0] code);
    logic [7:0] rel;
    rel = (code >= CMD_SPIN) ? code - CMD_SPIN : code;
    return rel[1:0];
  endfunction

  function automatic logic is_norm(input logic [7:0] code);
    return code <= CMD_NFALL;
  endfunction

  function automatic logic is_susp(input logic [7:0] code);
    return (code >= CMD_SPIN) && (code <= CMD_SFALL);
  endfunction
endpackage

// File: rtl/ioexp_bank.sv
module ioexp_bank #(
  parameter int   W        = 8,
  parameter logic PIN_ONES = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_slot,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] pin_q,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_q
);
  localparam int NSLOT = 3;
  logic [W-1:0] slot_q [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [W-1:0] POR = (s == 0 && !PIN_ONES) ? '0 : '1;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[s] <= POR;
      else if (soft_rst)
        slot_q[s] <= POR;
      else if (wr_en && wr_slot == 2'(s))
        slot_q[s] <= wr_data;
    end
  end

  assign pin_q  = slot_q[0];
  assign rise_q = slot_q[1];
  assign fall_q = slot_q[2];
endmodule

// File: rtl/ioexp_rdmux.sv
module ioexp_rdmux
  import ioexp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [7:0]   rd_code,
  input  logic [W-1:0] n_pin,
  input  logic [W-1:0] n_rise,
  input  logic [W-1:0] n_fall,
  input  logic [W-1:0] s_pin,
  input  logic [W-1:0] s_rise,
  input  logic [W-1:0] s_fall,
  input  logic [W-1:0] io_in,
  output logic [W-1:0] rd_data
);
  always_comb begin
    case (rd_code)
      CMD_NPIN:  rd_data = n_pin;
      CMD_NRISE: rd_data = n_rise;
      CMD_NFALL: rd_data = n_fall;
      CMD_SPIN:  rd_data = s_pin;
      CMD_SRISE: rd_data = s_rise;
      CMD_SFALL: rd_data = s_fall;
      CMD_STAT:  rd_data = io_in;
      CMD_ID:    rd_data = W'(ID_BYTE);
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ioexp_regfile.sv
module ioexp_regfile
  import ioexp_pkg::*;
#(
  parameter int W      = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cmd_code,
  input  logic              dat_stb,
  input  logic [W-1:0]      dat_byte,
  input  logic              cmd_stb,
  input  logic [7:0]        rd_code,
  output logic [W-1:0]      rd_data,
  input  logic              suspend,
  input  logic [W-1:0]      io_in,
  output logic [W-1:0]      io_out,
  output logic [W-1:0]      rise_mask,
  output logic [W-1:0]      fall_mask,
  input  logic [ADDR_W-1:0] addr_pins,
  output logic [ADDR_W-1:0] addr_sel
);
  // named events, also used by the checker
  logic soft_rst_evt, addr_smp_evt, norm_wr_evt, susp_wr_evt;
  logic [1:0] wr_slot;
  logic [W-1:0] n_pin, n_rise, n_fall, s_pin, s_rise, s_fall;
  logic [ADDR_W-1:0] addr_q;

  assign soft_rst_evt = cmd_stb && (cmd_code == CMD_SRST);
  assign addr_smp_evt = cmd_stb && (cmd_code == CMD_ASMP || cmd_code == CMD_SRST);
  assign norm_wr_evt  = dat_stb && is_norm(cmd_code);
  assign susp_wr_evt  = dat_stb && is_susp(cmd_code);
  assign wr_slot      = bank_slot(cmd_code);

  ioexp_bank #(.W(W), .PIN_ONES(1'b0)) u_norm (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_evt), .wr_en(norm_wr_evt),
    .wr_slot(wr_slot), .wr_data(dat_byte),
    .pin_q(n_pin), .rise_q(n_rise), .fall_q(n_fall));

  ioexp_bank #(.W(W), .PIN_ONES(1'b1)) u_susp (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_evt), .wr_en(susp_wr_evt),
    .wr_slot(wr_slot), .wr_data(dat_byte),
    .pin_q(s_pin), .rise_q(s_rise), .fall_q(s_fall));

  ioexp_rdmux #(.W(W)) u_rd (
    .rd_code(rd_code), .n_pin(n_pin), .n_rise(n_rise), .n_fall(n_fall),
    .s_pin(s_pin), .s_rise(s_rise), .s_fall(s_fall), .io_in(io_in),
    .rd_data(rd_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            addr_q <= '0;
    else if (addr_smp_evt) addr_q <= addr_pins;
  end

  assign addr_sel  = addr_q;
  assign io_out    = suspend ? s_pin  : n_pin;
  assign rise_mask = suspend ? s_rise : n_rise;
  assign fall_mask = suspend ? s_fall : n_fall;
endmodule

// File: rtl/ioexp_chk.sv
module ioexp_chk #(
  parameter int W      = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        cmd_code,
  input logic              dat_stb,
  input logic [W-1:0]      dat_byte,
  input logic [7:0]        rd_code,
  input logic [W-1:0]      rd_data,
  input logic              suspend,
  input logic [W-1:0]      io_in,
  input logic [W-1:0]      io_out,
  input logic [W-1:0]      rise_mask,
  input logic [W-1:0]      fall_mask,
  input logic [ADDR_W-1:0] addr_pins,
  input logic [ADDR_W-1:0] addr_sel,
  input logic              soft_rst_evt,
  input logic              addr_smp_evt,
  input logic [W-1:0]      n_pin,
  input logic [W-1:0]      n_rise,
  input logic [W-1:0]      n_fall,
  input logic [W-1:0]      s_pin,
  input logic [W-1:0]      s_rise,
  input logic [W-1:0]      s_fall
);
  // R2
  norm_pin_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_stb && cmd_code == 8'h00 |=> n_pin == $past(dat_byte));
  // R3
  susp_fall_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_stb && cmd_code == 8'h05 |=> s_fall == $past(dat_byte));
  // R4
  bank_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |-> (io_out == s_pin && rise_mask == s_rise && fall_mask == s_fall));
  // R5
  status_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_code == 8'h06 |-> rd_data == io_in);
  // R6
  addr_smp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_smp_evt |=> addr_sel == $past(addr_pins));
  // R7
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_evt |=> (n_pin == '0 && n_rise == '1 && n_fall == '1 &&
                      s_pin == '1 && s_rise == '1 && s_fall == '1));
  // R8
  id_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_code == 8'hFE |-> rd_data == W'(8'h4D));
  // R9
  undef_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_stb && cmd_code > 8'h05 && !soft_rst_evt |=>
      ($stable(n_pin) && $stable(n_rise) && $stable(n_fall) &&
       $stable(s_pin) && $stable(s_rise) && $stable(s_fall)));
endmodule

bind ioexp_regfile ioexp_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .dat_stb(dat_stb),
  .dat_byte(dat_byte), .rd_code(rd_code), .rd_data(rd_data),
  .suspend(suspend), .io_in(io_in), .io_out(io_out), .rise_mask(rise_mask),
  .fall_mask(fall_mask), .addr_pins(addr_pins), .addr_sel(addr_sel),
  .soft_rst_evt(soft_rst_evt), .addr_smp_evt(addr_smp_evt),
  .n_pin(n_pin), .n_rise(n_rise), .n_fall(n_fall),
  .s_pin(s_pin), .s_rise(s_rise), .s_fall(s_fall));

// File: tb/test_ioexp_regfile.sv
`timescale 1ns/1ps
module test_ioexp_regfile;
  localparam int W = 8;
  localparam int AW = 2;

  logic clk = 0, rst_n = 0;
  logic [7:0] cmd_code = 0, rd_code = 0;
  logic dat_stb = 0, cmd_stb = 0, suspend = 0;
  logic [W-1:0] dat_byte = 0, io_in = 0;
  logic [AW-1:0] addr_pins = 0;
  logic [W-1:0] rd_data, io_out, rise_mask, fall_mask;
  logic [AW-1:0] addr_sel;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  ioexp_regfile #(.W(W), .ADDR_W(AW)) i_ioexp_regfile (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .dat_stb(dat_stb),
    .dat_byte(dat_byte), .cmd_stb(cmd_stb), .rd_code(rd_code),
    .rd_data(rd_data), .suspend(suspend), .io_in(io_in), .io_out(io_out),
    .rise_mask(rise_mask), .fall_mask(fall_mask), .addr_pins(addr_pins),
    .addr_sel(addr_sel));

  task automatic check(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] c, input logic [W-1:0] d);
    @(negedge clk);
    cmd_code = c; dat_byte = d; dat_stb = 1;
    @(posedge clk); #1;
    dat_stb = 0;
  endtask

  task automatic act(input logic [7:0] c);
    @(negedge clk);
    cmd_code = c; cmd_stb = 1;
    @(posedge clk); #1;
    cmd_stb = 0;
  endtask

  task automatic rd(input logic [7:0] c, output logic [W-1:0] v);
    rd_code = c; #1; v = rd_data;
  endtask

  task automatic t_reset;
    logic [W-1:0] v;
    check("R1 io_out", io_out, 8'h00);
    check("R1 rise", rise_mask, 8'hFF);
    check("R1 fall", fall_mask, 8'hFF);
    check("R1 addr", addr_sel, 0);
    rd(8'h03, v); check("R1 susp pin", v, 8'hFF);
  endtask

  task automatic t_norm;
    logic [W-1:0] v;
    wr(8'h00, 8'hA5); wr(8'h01, 8'h3C); wr(8'h02, 8'h0F);
    check("R2 io_out", io_out, 8'hA5);
    check("R2 rise", rise_mask, 8'h3C);
    check("R2 fall", fall_mask, 8'h0F);
    rd(8'h01, v); check("R2 read 01", v, 8'h3C);
  endtask

  task automatic t_susp;
    logic [W-1:0] v;
    wr(8'h03, 8'h5A); wr(8'h04, 8'hC3); wr(8'h05, 8'hF0);
    check("R3 normal unchanged", io_out, 8'hA5);
    rd(8'h03, v); check("R3 read 03", v, 8'h5A);
    rd(8'h04, v); check("R3 read 04", v, 8'hC3);
    rd(8'h05, v); check("R3 read 05", v, 8'hF0);
  endtask

  task automatic t_select;
    @(negedge clk); suspend = 1; #1;
    check("R4 susp io", io_out, 8'h5A);
    check("R4 susp rise", rise_mask, 8'hC3);
    check("R4 susp fall", fall_mask, 8'hF0);
    suspend = 0; #1;
    check("R4 back normal", io_out, 8'hA5);
  endtask

  task automatic t_status;
    logic [W-1:0] v;
    io_in = 8'h96; rd(8'h06, v); check("R5 status", v, 8'h96);
    io_in = 8'h21; rd(8'h06, v); check("R5 status live", v, 8'h21);
    wr(8'h06, 8'h77);
    rd(8'h00, v); check("R5 wr ignored n", v, 8'hA5);
    rd(8'h03, v); check("R5 wr ignored s", v, 8'h5A);
  endtask

  task automatic t_addr;
    addr_pins = 2'b10; act(8'h07);
    check("R6 sample", addr_sel, 2'b10);
    addr_pins = 2'b01; #1;
    check("R6 holds", addr_sel, 2'b10);
  endtask

  task automatic t_id_undef;
    logic [W-1:0] v;
    rd(8'hFE, v); check("R8 id", v, 8'h4D);
    wr(8'hFE, 8'h11);
    rd(8'hFE, v); check("R8 id after wr", v, 8'h4D);
    rd(8'h01, v); check("R8 wr ignored", v, 8'h3C);
    rd(8'h09, v); check("R9 read 09", v, 8'h00);
    rd(8'hFF, v); check("R9 read FF", v, 8'h00);
    wr(8'h83, 8'h00);
    rd(8'h00, v); check("R9 wr ignored n", v, 8'hA5);
    rd(8'h05, v); check("R9 wr ignored s", v, 8'hF0);
  endtask

  task automatic t_timing;
    @(negedge clk);
    cmd_code = 8'h00; dat_byte = 8'h42; dat_stb = 1; #1;
    check("R10 before edge", io_out, 8'hA5);
    @(posedge clk); #1; dat_stb = 0;
    check("R10 after edge", io_out, 8'h42);
  endtask

  task automatic t_soft;
    logic [W-1:0] v;
    addr_pins = 2'b11; act(8'h08);
    check("R7 io_out", io_out, 8'h00);
    check("R7 rise", rise_mask, 8'hFF);
    check("R7 fall", fall_mask, 8'hFF);
    check("R7 addr", addr_sel, 2'b11);
    rd(8'h03, v); check("R7 susp pin", v, 8'hFF);
    rd(8'h05, v); check("R7 susp fall", v, 8'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    t_reset();
    t_norm();
    t_susp();
    t_select();
    t_status();
    t_addr();
    t_id_undef();
    t_timing();
    t_soft();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule